// File: doc/BRIEF.md
# Instruction Operand Address Generator

This block forms the memory operand address for a fixed-width 16-bit instruction word. It receives a start pulse with the instruction, the current program counter and the contents of two index registers. From two addressing bits in the instruction it picks a base, and it combines that base with the 8-bit displacement field. The result is a full 16-bit address, even though the instruction carries only eight address bits.

Some opcodes are deferred forms. For these, the computed address points at a pointer word in memory. The block raises a one-cycle read request for that location and waits for the read data to come back. The returned word then becomes the operand address. Direct forms finish one cycle after the start pulse.

Top module: `ea_gen`

## Requirements
- R1: During and after reset, `ea_valid` and `rd_req` are low and `ea_addr` and `rd_addr` are zero.
- R2: The instruction fields sit at fixed positions: opcode in bits 15..10, index-select bit in bit 9, relative bit in bit 8, displacement in bits 7..0. With bits 9..8 = 00, the address is the displacement zero-extended into page zero.
- R3: With bits 9..8 = 01, the address is `pc` plus the sign-extended displacement.
- R4: With bits 9..8 = 10, the address is `idx_lo` plus the sign-extended displacement.
- R5: With bits 9..8 = 11, the address is `idx_hi` plus the sign-extended displacement.
- R6: All address sums wrap modulo 65536.
- R7: For an opcode outside the deferred set, `ea_valid` is high for exactly the one cycle after the accepted start, with the address on `ea_addr`, and `rd_req` stays low. Starts in consecutive idle cycles give results in consecutive cycles.
- R8: For an opcode in the deferred set (defaults 0x22, 0x23, 0x32, 0x33), `rd_req` pulses for the one cycle after the start, with the computed address on `rd_addr`. No `ea_valid` is raised in that cycle.
- R9: While a pointer read is pending, `rd_valid` causes `ea_valid` to pulse in the next cycle, with `ea_addr` equal to the `rd_data` that came with it.
- R10: While a pointer read is pending, `start` is ignored: it produces neither `ea_valid` nor `rd_req`.
- R11: `rd_valid` while no read is pending is ignored and produces no `ea_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request an address for the inputs present this cycle |
| instr | input | 16 | Instruction word |
| pc | input | 16 | Program counter |
| idx_lo | input | 16 | First index register |
| idx_hi | input | 16 | Second index register |
| rd_valid | input | 1 | Pointer read data valid |
| rd_data | input | 16 | Pointer word returned by memory |
| ea_valid | output | 1 | Final address strobe |
| ea_addr | output | 16 | Final operand address |
| rd_req | output | 1 | Pointer read request pulse |
| rd_addr | output | 16 | Pointer location to read |

## Verification
The properties assume three things about the memory side. First, `rd_valid` is the only input that ends a pending pointer read. Second, the memory answers each request exactly once. Third, the inputs that go with `start` are stable at the sampling edge. The bench honours all three. It drives every input on the falling edge. It raises `rd_valid` only after it has seen a request, or on purpose while idle to exercise R11. It returns exactly one word per request.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [1:0] {
        MODE_PAGE0 = 2'b00,
        MODE_PCREL = 2'b01,
        MODE_IDXLO = 2'b10,
        MODE_IDXHI = 2'b11
    } ea_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ea_state_e;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
    import ea_pkg::*;
#(
    parameter int AW    = 16,
    parameter int OPW   = 6,
    parameter int DW    = 8,
    parameter int N_IND = 4,
    parameter logic [N_IND*OPW-1:0] IND_CODES = '0
) (
    input  logic [AW-1:0] instr,
    output ea_mode_e      mode,
    output logic [DW-1:0] disp,
    output logic          is_ind
);
    localparam int XBIT = DW + 1;
    localparam int RBIT = DW;

    logic [OPW-1:0]   opcode;
    logic [N_IND-1:0] hit;

    assign opcode = instr[AW-1:AW-OPW];
    assign disp   = instr[DW-1:0];
    assign mode   = ea_mode_e'({instr[XBIT], instr[RBIT]});

    for (genvar i = 0; i < N_IND; i++) begin : g_match
        assign hit[i] = (opcode == IND_CODES[i*OPW +: OPW]);
    end

    assign is_ind = |hit;
endmodule

// File: rtl/ea_base_sel.sv
module ea_base_sel
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  ea_mode_e      mode,
    input  logic [DW-1:0] disp,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] idx_lo,
    input  logic [AW-1:0] idx_hi,
    output logic [AW-1:0] addr
);
    localparam int EXT = AW - DW;

    logic [AW-1:0] disp_zx;
    logic [AW-1:0] disp_sx;
    logic [AW-1:0] base;

    assign disp_zx = {{EXT{1'b0}}, disp};
    assign disp_sx = {{EXT{disp[DW-1]}}, disp};

    always_comb begin
        case (mode)
            MODE_PCREL: base = pc;
            MODE_IDXLO: base = idx_lo;
            MODE_IDXHI: base = idx_hi;
            default:    base = '0;
        endcase
        if (mode == MODE_PAGE0) addr = disp_zx;
        else                    addr = base + disp_sx;
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int AW    = 16,
    parameter int OPW   = 6,
    parameter int DW    = 8,
    parameter int N_IND = 4,
    parameter logic [N_IND*OPW-1:0] IND_CODES = {6'h33, 6'h32, 6'h23, 6'h22}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] instr,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] idx_lo,
    input  logic [AW-1:0] idx_hi,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_data,
    output logic          ea_valid,
    output logic [AW-1:0] ea_addr,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr
);
    typedef struct packed {
        ea_state_e     st;
        logic          ea_valid;
        logic [AW-1:0] ea_addr;
        logic          rd_req;
        logic [AW-1:0] rd_addr;
    } regs_t;

    ea_mode_e      mode;
    logic [DW-1:0] disp;
    logic          is_ind;
    logic [AW-1:0] calc_addr;
    regs_t         r_d;
    regs_t         r_q;

    ea_decode #(
        .AW(AW), .OPW(OPW), .DW(DW), .N_IND(N_IND), .IND_CODES(IND_CODES)
    ) u_dec (
        .instr  (instr),
        .mode   (mode),
        .disp   (disp),
        .is_ind (is_ind)
    );

    ea_base_sel #(.AW(AW), .DW(DW)) u_sel (
        .mode   (mode),
        .disp   (disp),
        .pc     (pc),
        .idx_lo (idx_lo),
        .idx_hi (idx_hi),
        .addr   (calc_addr)
    );

    always_comb begin
        r_d          = r_q;
        r_d.ea_valid = 1'b0;
        r_d.rd_req   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (is_ind) begin
                        r_d.rd_req  = 1'b1;
                        r_d.rd_addr = calc_addr;
                        r_d.st      = ST_WAIT;
                    end else begin
                        r_d.ea_valid = 1'b1;
                        r_d.ea_addr  = calc_addr;
                    end
                end
            end
            default: begin
                if (rd_valid) begin
                    r_d.ea_valid = 1'b1;
                    r_d.ea_addr  = rd_data;
                    r_d.st       = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign ea_valid = r_q.ea_valid;
    assign ea_addr  = r_q.ea_addr;
    assign rd_req   = r_q.rd_req;
    assign rd_addr  = r_q.rd_addr;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] instr,
    input logic [AW-1:0] pc,
    input logic          rd_valid,
    input logic [AW-1:0] rd_data,
    input logic          ea_valid,
    input logic [AW-1:0] ea_addr,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr
);
    localparam int EXT = AW - DW;

    logic pend_q;
    logic waiting;

    assign waiting = pend_q || rd_req;

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= waiting && !rd_valid;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !ea_valid && !rd_req && ea_addr == '0 && rd_addr == '0);

    assert_page_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !waiting && instr[DW+1:DW] == 2'b00 |=>
        (ea_valid && ea_addr == {{EXT{1'b0}}, $past(instr[DW-1:0])}) ||
        (rd_req && rd_addr == {{EXT{1'b0}}, $past(instr[DW-1:0])}));

    assert_pc_rel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start && !waiting && instr[DW+1:DW] == 2'b01 |=>
        (ea_valid && ea_addr == $past(pc) + {{EXT{$past(instr[DW-1])}}, $past(instr[DW-1:0])}) ||
        (rd_req && rd_addr == $past(pc) + {{EXT{$past(instr[DW-1])}}, $past(instr[DW-1:0])}));

    assert_one_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ea_valid && rd_req));

    assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    assert_ptr_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && rd_valid |=> ea_valid && ea_addr == $past(rd_data));

    assert_hold_while_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && !rd_valid |=> !ea_valid && !rd_req);

    assert_idle_rdvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !waiting && !start |=> !ea_valid && !rd_req);
endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .instr    (instr),
    .pc       (pc),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .ea_valid (ea_valid),
    .ea_addr  (ea_addr),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] pc = '0;
    logic [15:0] idx_lo = '0;
    logic [15:0] idx_hi = '0;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_data = '0;
    logic        ea_valid;
    logic [15:0] ea_addr;
    logic        rd_req;
    logic [15:0] rd_addr;

    int checks = 0;
    int fails = 0;
    int seen = 0;
    bit ended = 0;
    logic [16:0] expq[$];
    string tagq[$];

    always #10 clk = ~clk;

    ea_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc(pc),
        .idx_lo(idx_lo), .idx_hi(idx_hi), .rd_valid(rd_valid), .rd_data(rd_data),
        .ea_valid(ea_valid), .ea_addr(ea_addr), .rd_req(rd_req), .rd_addr(rd_addr)
    );

    function automatic logic [15:0] mk(input logic [5:0] op, input logic [1:0] xr,
                                       input logic [7:0] d);
        return {op, xr, d};
    endfunction

    function automatic logic [15:0] want(input logic [15:0] ins, input logic [15:0] p,
                                         input logic [15:0] a, input logic [15:0] b);
        logic [15:0] sx;
        sx = {{8{ins[7]}}, ins[7:0]};
        case (ins[9:8])
            2'b00:   return {8'h00, ins[7:0]};
            2'b01:   return p + sx;
            2'b10:   return a + sx;
            default: return b + sx;
        endcase
    endfunction

    function automatic bit deferred(input logic [15:0] ins);
        return ins[15:10] inside {6'h22, 6'h23, 6'h32, 6'h33};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] ins, input logic [15:0] p,
                         input logic [15:0] a, input logic [15:0] b, input string tag);
        start = 1'b1; instr = ins; pc = p; idx_lo = a; idx_hi = b;
        expq.push_back({deferred(ins), want(ins, p, a, b)});
        tagq.push_back(tag);
        @(negedge clk);
    endtask

    task automatic stop();
        start = 1'b0;
    endtask

    task automatic give(input logic [15:0] d, input string tag);
        rd_valid = 1'b1; rd_data = d;
        expq.push_back({1'b0, d});
        tagq.push_back(tag);
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (rst_n && (ea_valid || rd_req)) begin
                seen++;
                if (expq.size() == 0) begin
                    check("R10/R11 unexpected output", {15'd0, rd_req, ea_valid}, 32'd0);
                end else begin
                    logic [16:0] e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    check(t, {15'd0, rd_req, rd_req ? rd_addr : ea_addr},
                          {15'd0, e[16], e[15:0]});
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin : main
        int snap;
        repeat (3) @(negedge clk);
        check("R1 reset ea_valid/rd_req", {30'd0, ea_valid, rd_req}, 32'd0);
        check("R1 reset addrs", {ea_addr, rd_addr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        drive(mk(6'h01, 2'b00, 8'hA5), 16'h1234, 16'h5555, 16'h6666, "R2 page zero");
        stop(); @(negedge clk);
        drive(mk(6'h01, 2'b01, 8'h10), 16'h1000, 16'h0, 16'h0, "R3 pc fwd");
        drive(mk(6'h01, 2'b01, 8'hF0), 16'h1000, 16'h0, 16'h0, "R3 pc back R7 consecutive");
        drive(mk(6'h02, 2'b10, 8'h7F), 16'h0, 16'h2000, 16'h9999, "R4 idx_lo");
        drive(mk(6'h02, 2'b11, 8'h80), 16'h0, 16'h9999, 16'h3000, "R5 idx_hi");
        drive(mk(6'h03, 2'b01, 8'h20), 16'hFFF0, 16'h0, 16'h0, "R6 wrap up");
        drive(mk(6'h03, 2'b10, 8'hF0), 16'h0, 16'h0005, 16'h0, "R6 wrap down");
        stop(); @(negedge clk);

        drive(mk(6'h22, 2'b11, 8'h02), 16'h0, 16'h0, 16'h4000, "R8 ptr read");
        stop();
        snap = seen;
        drive(mk(6'h01, 2'b00, 8'h11), 16'h0, 16'h0, 16'h0, "R10 ignored");
        void'(expq.pop_back()); void'(tagq.pop_back());
        stop();
        repeat (3) @(negedge clk);
        check("R10 no output while pending", seen, snap);
        give(16'hBEEF, "R9 pointer word");
        @(negedge clk);

        snap = seen;
        rd_valid = 1'b1; rd_data = 16'h7777;
        @(negedge clk);
        rd_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 idle rd_valid ignored", seen, snap);

        drive(mk(6'h33, 2'b00, 8'hC4), 16'h0, 16'h0, 16'h0, "R8 ptr page zero");
        stop();
        @(negedge clk);
        give(16'h0042, "R9 pointer word 2");
        drive(mk(6'h05, 2'b01, 8'h01), 16'h0100, 16'h0, 16'h0, "R7 after ptr");
        stop();
        repeat (3) @(negedge clk);
        check("R7 scoreboard drained", expq.size(), 0);
        report();
    end
endmodule